// File: doc/BRIEF.md
# Framed Serializer with Counter Test Pattern

This block turns a stream of 6-bit parallel words into a single NRZ serial bit stream, one bit per clock. Every word travels inside an 8-bit frame that also carries an even-parity bit and one bit of a distributed synchronization code. The sync code is 8 bits long and is spread over eight consecutive frames, one bit per frame. A receiver can therefore locate frame boundaries by searching for the code, and it can check each word against its parity bit.

Words enter through a ready/valid handshake. Input is taken only at frame boundaries. If no word is offered at a boundary, the previous word is sent again and an underrun flag is raised for that frame. A mode input replaces the external data with an internal free-running binary counter. This gives a known ramp pattern for link testing. Nothing depends on the clock frequency: all timing is counted in clock cycles.

Top module: `fs_frame_serializer`

## Requirements
- R1: A frame is FRAME_W = DATA_W+2 bits long and is sent one bit per clock on `ser_out`, MSB first. Bit 7 is the sync bit, bit 6 is the parity bit, and bits 5..0 are the data word, MSB first. Each bit is held for exactly one clock (NRZ).
- R2: `frame_start` is high during the clock in which bit 7 of a frame is on `ser_out`, and low during the other FRAME_W-1 bits. Frames follow each other with no gap, so the strobe repeats every FRAME_W clocks.
- R3: The parity bit makes the number of ones across the parity bit and the six data bits even.
- R4: The sync bits of successive frames follow the code 8'b1110_0100, MSB first. The first frame after reset carries bit 7 of the code, and the sequence repeats every 8 frames.
- R5: In data mode (`test_mode`=0), `in_ready` is high only in the clock that carries the last bit of a frame. A word offered with `in_valid` high in that clock is sent as the data field of the next frame.
- R6: If `in_valid` is low at a data-mode boundary, the next frame repeats the most recently accepted word (0 after reset). `underrun` is then high for that whole frame. The repeated word is the last accepted one even when counter-mode frames came in between. `underrun` returns low on the next frame that does not underrun.
- R7: In counter mode (`test_mode`=1), the data field comes from a counter instead of the input. The counter is 0 after reset and advances by one per counter-mode frame, wrapping from 63 to 0. In this mode `in_ready` stays low, `in_valid` and `in_data` have no effect, and `underrun` stays low.
- R8: During reset, `ser_out`, `frame_start` and `underrun` are low, and `in_ready` is high in data mode. The first frame begins on the first clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | DATA_W | Parallel data word |
| in_valid | input | 1 | `in_data` holds a word |
| in_ready | output | 1 | Word accepted at this clock edge if valid |
| test_mode | input | 1 | 1 selects the internal counter as the data source |
| ser_out | output | 1 | NRZ serial output, registered |
| frame_start | output | 1 | High during the first bit of each frame |
| underrun | output | 1 | Current frame repeats the previous word |

## Verification
The bench builds the block with its default 6-bit data field, 8-bit frame and 8-bit sync code. These sizes are small enough to send all 64 data values and to run the counter for more than a full lap, so the 63-to-0 wrap is covered. At that length the sync code cycles many times, and it is compared against each frame's index from reset. A mid-run reset and single and consecutive underruns are also covered. So is a mode switch back to data mode, which must repeat the word accepted before the counter frames.

// File: rtl/fs_pkg.sv
package fs_pkg;
  // Frame overhead on top of the data field: one sync bit, one parity bit.
  localparam int FS_OVERHEAD = 2;

  typedef enum logic {
    SRC_EXTERNAL = 1'b0,
    SRC_COUNTER  = 1'b1
  } fs_src_e;
endpackage

// File: rtl/fs_bit_timer.sv
module fs_bit_timer #(
  parameter int FRAME_W = 8
) (
  input  logic clk,
  input  logic rst,
  output logic boundary
);
  localparam int CNT_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [CNT_W-1:0] bit_cnt;

  // Reset parks the counter on the last slot, so the first edge loads a frame.
  always_ff @(posedge clk) begin
    if (rst)           bit_cnt <= LAST;
    else if (boundary) bit_cnt <= '0;
    else               bit_cnt <= bit_cnt + 1'b1;
  end

  assign boundary = (bit_cnt == LAST);
endmodule

// File: rtl/fs_sync_gen.sv
module fs_sync_gen #(
  parameter int                  SYNC_LEN  = 8,
  parameter logic [SYNC_LEN-1:0] SYNC_CODE = 8'hE4
) (
  input  logic clk,
  input  logic rst,
  input  logic advance,
  output logic sync_bit
);
  logic [SYNC_LEN-1:0] code_q;

  generate
    if (SYNC_LEN > 1) begin : g_rotate
      always_ff @(posedge clk) begin
        if (rst)          code_q <= SYNC_CODE;
        else if (advance) code_q <= {code_q[SYNC_LEN-2:0], code_q[SYNC_LEN-1]};
      end
    end else begin : g_fixed
      always_ff @(posedge clk) begin
        if (rst) code_q <= SYNC_CODE;
      end
    end
  endgenerate

  assign sync_bit = code_q[SYNC_LEN-1];
endmodule

// File: rtl/fs_pattern_src.sv
module fs_pattern_src #(
  parameter int DATA_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  output logic [DATA_W-1:0] pattern
);
  // Binary counter that wraps naturally at 2**DATA_W.
  always_ff @(posedge clk) begin
    if (rst)          pattern <= '0;
    else if (advance) pattern <= pattern + 1'b1;
  end
endmodule

// File: rtl/fs_frame_serializer.sv
module fs_frame_serializer #(
  parameter int                  DATA_W    = 6,
  parameter int                  SYNC_LEN  = 8,
  parameter logic [SYNC_LEN-1:0] SYNC_CODE = 8'hE4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              test_mode,
  output logic              ser_out,
  output logic              frame_start,
  output logic              underrun
);
  import fs_pkg::*;

  localparam int FRAME_W = DATA_W + FS_OVERHEAD;

  fs_src_e           src_sel;
  logic              boundary;
  logic              take;
  logic              sync_bit;
  logic [DATA_W-1:0] pattern;
  logic [DATA_W-1:0] last_word;
  logic [DATA_W-1:0] word;
  logic              parity;
  logic [FRAME_W-1:0] frame_next;
  logic [FRAME_W-1:0] shreg;

  assign src_sel = test_mode ? SRC_COUNTER : SRC_EXTERNAL;

  fs_bit_timer #(.FRAME_W(FRAME_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .boundary (boundary)
  );

  fs_sync_gen #(.SYNC_LEN(SYNC_LEN), .SYNC_CODE(SYNC_CODE)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .advance  (boundary),
    .sync_bit (sync_bit)
  );

  fs_pattern_src #(.DATA_W(DATA_W)) u_pattern (
    .clk     (clk),
    .rst     (rst),
    .advance (boundary && (src_sel == SRC_COUNTER)),
    .pattern (pattern)
  );

  assign in_ready = boundary && (src_sel == SRC_EXTERNAL);
  assign take     = in_ready && in_valid;

  always_comb begin
    if (src_sel == SRC_COUNTER) word = pattern;
    else if (take)              word = in_data;
    else                        word = last_word;
    parity     = ^word;
    frame_next = {sync_bit, parity, word};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg       <= '0;
      last_word   <= '0;
      frame_start <= 1'b0;
      underrun    <= 1'b0;
    end else if (boundary) begin
      shreg       <= frame_next;
      frame_start <= 1'b1;
      underrun    <= (src_sel == SRC_EXTERNAL) && !in_valid;
      if (take) last_word <= in_data;
    end else begin
      shreg       <= {shreg[FRAME_W-2:0], 1'b0};
      frame_start <= 1'b0;
    end
  end

  assign ser_out = shreg[FRAME_W-1];
endmodule

// File: rtl/fs_serializer_chk.sv
module fs_serializer_chk #(
  parameter int FRAME_W = 8
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic test_mode,
  input logic ser_out,
  input logic frame_start,
  input logic underrun
);
  logic [7:0] since;
  logic       seen;
  logic       acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      since <= 8'd0;
      seen  <= 1'b0;
      acc   <= 1'b0;
    end else begin
      if (frame_start)        since <= 8'd1;
      else if (since != 8'hFF) since <= since + 8'd1;
      seen <= seen | frame_start;
      acc  <= frame_start ? 1'b0 : (acc ^ ser_out);
    end
  end

  // R2
  frame_period_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_start && seen) |-> (since == 8'(FRAME_W)));

  // R3
  even_parity_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_start && seen) |-> (acc == 1'b0));

  // R5
  ready_load_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> frame_start);

  // R6
  underrun_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(underrun) |-> $past(!in_valid && !test_mode));

  // R7
  counter_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
    test_mode |-> !in_ready);
endmodule

bind fs_frame_serializer fs_serializer_chk #(.FRAME_W(DATA_W + 2)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .test_mode   (test_mode),
  .ser_out     (ser_out),
  .frame_start (frame_start),
  .underrun    (underrun)
);

// File: tb/test_fs_frame_serializer.sv
`timescale 1ns/1ps
module test_fs_frame_serializer;
  localparam int DATA_W = 6;
  localparam logic [7:0] CODE = 8'hE4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DATA_W-1:0] in_data = '0;
  logic in_valid = 1'b0;
  logic test_mode = 1'b0;
  logic in_ready, ser_out, frame_start, underrun;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int fidx = 0;
  logic [DATA_W-1:0] pat_model = '0;
  logic [DATA_W-1:0] last_model = '0;

  always #2.5 clk = ~clk;

  fs_frame_serializer i_fs_frame_serializer (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .test_mode(test_mode), .ser_out(ser_out),
    .frame_start(frame_start), .underrun(underrun)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cycles, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Called at a negedge where the frame's last bit slot is active.
  task automatic send(input logic mode, input logic valid, input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] ed;
    logic eu, es;
    logic [7:0] got;
    es = CODE[7 - (fidx % 8)];
    if (mode) begin
      ed = pat_model; pat_model = pat_model + 1'b1; eu = 1'b0;
    end else if (valid) begin
      ed = d; last_model = d; eu = 1'b0;
    end else begin
      ed = last_model; eu = 1'b1;
    end
    test_mode = mode; in_valid = valid; in_data = d;
    #1;
    chk(in_ready == !mode, mode ? "R7 ready low" : "R5 ready high", in_ready, !mode);
    got = '0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i == 0) begin
        chk(frame_start == 1'b1, "R2 strobe on first bit", frame_start, 1);
        chk(underrun == eu, mode ? "R7 no underrun" : "R6 underrun flag", underrun, eu);
      end
      if (i == 1) chk(frame_start == 1'b0, "R2 strobe low", frame_start, 0);
      if (i == 3) chk(in_ready == 1'b0, "R5 ready mid-frame", in_ready, 0);
      got = {got[6:0], ser_out};
    end
    chk(got[7] == es, "R4 sync bit", got[7], es);
    chk(got[6] == ^got[5:0], "R3 even parity", got[6], ^got[5:0]);
    chk(got[5:0] == ed, mode ? "R7 counter data" : "R1 data field", got[5:0], ed);
    fidx++;
  endtask

  task automatic do_reset();
    rst = 1'b1; test_mode = 1'b0; in_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(ser_out == 1'b0, "R8 ser_out reset", ser_out, 0);
    chk(frame_start == 1'b0, "R8 strobe reset", frame_start, 0);
    chk(underrun == 1'b0, "R8 underrun reset", underrun, 0);
    chk(in_ready == 1'b1, "R8 ready reset", in_ready, 1);
    rst = 1'b0;
    fidx = 0; pat_model = '0; last_model = '0;
  endtask

  initial begin
    do_reset();
    // R1 R5: every data value
    for (int v = 0; v < 64; v++) send(1'b0, 1'b1, DATA_W'(v));
    // R6: single and consecutive underruns
    send(1'b0, 1'b0, 6'h15);
    send(1'b0, 1'b0, 6'h00);
    send(1'b0, 1'b1, 6'h2B);
    send(1'b0, 1'b0, 6'h3F);
    // R7: counter over more than a full lap, input ignored
    for (int k = 0; k < 70; k++) send(1'b1, 1'b1, 6'h2A);
    // R6: underrun after counter frames repeats last accepted word
    send(1'b0, 1'b0, 6'h11);
    send(1'b0, 1'b1, 6'h01);
    // R8 R4 R6 R7: restart after a mid-run reset
    do_reset();
    send(1'b0, 1'b0, 6'h3C);
    send(1'b1, 1'b0, 6'h00);
    send(1'b1, 1'b1, 6'h07);
    send(1'b0, 1'b1, 6'h22);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule